// File: doc/BRIEF.md
# Three-Wire Serial Register Write Receiver

This block takes register writes from a three-wire serial control bus (serial clock, serial data, latch strobe) and turns each one into a single-cycle parallel write into a register file running on the system clock. Bits are shifted in one per rising serial-clock edge. A rising edge on the latch line commits the most recent sixteen bits as a control word. The upper seven bits of the word are the register address and the lower nine bits are the register data.

All three bus lines are asynchronous to the system clock. Each passes through a two-flop synchroniser, and edges are detected on the synchronised copies. A word is accepted only when at least sixteen bits have arrived since the previous latch. A static interface-select input turns the receiver off when the system uses the two-wire bus instead.

Top module: `tws_write_slave`

## Requirements
- R1: The first bit shifted in becomes word bit 15. The write address is word bits 15..9 and the write data is word bits 8..0.
- R2: One serial data bit is captured on each rising edge of `serClk`. The data must be stable for at least two system clock cycles around that edge.
- R3: A rising edge on `serLatch` commits the last 16 captured bits. Any bits shifted in before those 16 are discarded.
- R4: An accepted word produces `wrEn` high for exactly one system clock cycle. `wrAddr` and `wrData` carry the word on that same cycle.
- R5: `wrAddr` and `wrData` keep their values between accepted words.
- R6: A latch edge that arrives after fewer than 16 captured bits since the previous latch edge (or since reset) is rejected, and no `wrEn` pulse is issued.
- R7: While `threeWireSel` is 0, clock and latch edges have no effect. No write is issued, and bits shifted during that time do not count toward a later word.
- R8: A synchronous active-low reset drives `wrEn` to 0 and `wrAddr` and `wrData` to 0, and clears the bit count.
- R9: Every latch edge clears the bit count, including a rejected one. A full 16 new bits are then needed before the next accepted latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| threeWireSel | input | 1 | 1 enables the three-wire receiver; 0 selects the two-wire bus and idles this block |
| serClk | input | 1 | Serial bit clock, asynchronous |
| serData | input | 1 | Serial data, most significant bit first |
| serLatch | input | 1 | Word latch strobe; its rising edge commits the word |
| wrEn | output | 1 | One-cycle register write strobe |
| wrAddr | output | 7 | Register address |
| wrData | output | 9 | Register data |

## Verification
Words with distinct, asymmetric bit patterns (alternating bits, all-ones address with all-zero data, and the reverse) are sent. These show whether the address/data split and the bit order are right, since a reversed or shifted word yields a different address. Frames longer than sixteen bits, with differing leading junk, separate "keep the last sixteen" from "keep the first sixteen". Short frames, frames split by a rejected latch, and traffic sent while the interface is deselected each check that a write strobe appears only when a full word has arrived in three-wire mode.

// File: rtl/tws_pkg.sv
package tws_pkg;
  // Strobes from control to datapath, valid for one system clock cycle
  typedef struct packed {
    logic shiftEn;  // capture one serial bit
    logic loadEn;   // commit the shift register to the write port
  } twsStrobes_t;
endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  for (genvar i = 0; i < WIDTH; i++) begin : gLine
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[STAGES-2:0], asyncIn[i]};
    end
    assign syncOut[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/tws_ctrl.sv
module tws_ctrl
  import tws_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        sclkSync,
  input  logic        latchSync,
  output twsStrobes_t strobes
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic             sclkPrev, latchPrev;
  logic [CNT_W-1:0] bitCount;
  logic             sclkRise, latchRise, wordFull;

  assign sclkRise  = sclkSync & ~sclkPrev;
  assign latchRise = latchSync & ~latchPrev;
  assign wordFull  = (bitCount == FULL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkPrev  <= 1'b0;
      latchPrev <= 1'b0;
    end else begin
      sclkPrev  <= sclkSync;
      latchPrev <= latchSync;
    end
  end

  // Saturating count of bits since the last latch; cleared when idle
  always_ff @(posedge clk) begin
    if (!rstN || !enable)      bitCount <= '0;
    else if (latchRise)        bitCount <= '0;
    else if (sclkRise && !wordFull) bitCount <= bitCount + 1'b1;
  end

  always_comb begin
    strobes.shiftEn = enable & sclkRise & ~latchRise;
    strobes.loadEn  = enable & latchRise & wordFull;
  end
endmodule

// File: rtl/tws_dpath.sv
module tws_dpath
  import tws_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  twsStrobes_t       strobes,
  input  logic              dataSync,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData
);
  localparam int WORD_W = ADDR_W + DATA_W;

  logic [WORD_W-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN)                shiftReg <= '0;
    else if (strobes.shiftEn) shiftReg <= {shiftReg[WORD_W-2:0], dataSync};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrEn   <= 1'b0;
      wrAddr <= '0;
      wrData <= '0;
    end else begin
      wrEn <= strobes.loadEn;
      if (strobes.loadEn) begin
        wrAddr <= shiftReg[WORD_W-1:DATA_W];
        wrData <= shiftReg[DATA_W-1:0];
      end
    end
  end
endmodule

// File: rtl/tws_write_slave.sv
module tws_write_slave
  import tws_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              threeWireSel,
  input  logic              serClk,
  input  logic              serData,
  input  logic              serLatch,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData
);
  localparam int WORD_W = ADDR_W + DATA_W;

  logic [2:0]  syncLines;
  twsStrobes_t strobes;

  tws_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) uSync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({serLatch, serData, serClk}),
    .syncOut (syncLines)
  );

  tws_ctrl #(.WORD_W(WORD_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (threeWireSel),
    .sclkSync  (syncLines[0]),
    .latchSync (syncLines[2]),
    .strobes   (strobes)
  );

  tws_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .dataSync (syncLines[1]),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData)
  );
endmodule

// File: rtl/tws_write_slave_chk.sv
module tws_write_slave_chk #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              threeWireSel,
  input logic              serLatch,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData
);
  // R4: the write strobe never lasts two cycles
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !wrEn);

  // R5: address and data move only on a write cycle
  a_r5_hold_outputs: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> ($stable(wrAddr) && $stable(wrData)));

  // R7: no write follows a cycle with the receiver deselected
  a_r7_idle_no_write: assert property (@(posedge clk) disable iff (!rstN)
    !$past(threeWireSel) |-> !wrEn);

  // R8: reset clears the strobe and the write port
  a_r8_reset_clears: assert property (@(posedge clk)
    !rstN |=> (!wrEn && wrAddr == '0 && wrData == '0));

  // R3: a commit needs a latch line that has been high lately
  a_r3_latch_cause: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> ($past(serLatch) || $past(serLatch, 2) || $past(serLatch, 3)));
endmodule

bind tws_write_slave tws_write_slave_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .threeWireSel (threeWireSel),
  .serLatch     (serLatch),
  .wrEn         (wrEn),
  .wrAddr       (wrAddr),
  .wrData       (wrData)
);

// File: tb/sim_tws_write_slave.sv
module sim_tws_write_slave;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       threeWireSel = 1'b1;
  logic       serClk = 1'b0;
  logic       serData = 1'b0;
  logic       serLatch = 1'b0;
  logic       wrEn;
  logic [6:0] wrAddr;
  logic [8:0] wrData;

  int checks = 0;
  int fails  = 0;
  logic [15:0] expQ[$];
  logic        prevWrEn = 1'b0;
  logic        done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  tws_write_slave u0 (
    .clk(clk), .rstN(rstN), .threeWireSel(threeWireSel),
    .serClk(serClk), .serData(serData), .serLatch(serLatch),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData)
  );

  task automatic check(input bit ok, input string req, input string msg,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, msg, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  task automatic shiftBits(input logic [31:0] val, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      serData = val[i];
      waitCycles(4);
      serClk = 1'b1;
      waitCycles(4);
      serClk = 1'b0;
      waitCycles(2);
    end
  endtask

  task automatic pulseLatch();
    serLatch = 1'b1;
    waitCycles(4);
    serLatch = 1'b0;
    waitCycles(4);
  endtask

  // Driver: shift n bits, latch, and queue the expected word when accepted
  task automatic sendWord(input logic [31:0] val, input int n, input bit accept);
    shiftBits(val, n);
    if (accept) expQ.push_back(val[15:0]);
    pulseLatch();
  endtask

  task automatic drain(input string req);
    waitCycles(10);
    check(expQ.size() == 0, req, "expected write missing", expQ.size(), 0);
    expQ.delete();
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      check(!(prevWrEn && wrEn), "R4", "strobe longer than one cycle", 2, 1);
      if (wrEn) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R6", "unexpected write", {wrAddr, wrData}, 0);
        end else begin
          logic [15:0] e;
          e = expQ.pop_front();
          check(wrAddr == e[15:9], "R1", "address", wrAddr, e[15:9]);
          check(wrData == e[8:0],  "R1", "data",    wrData, e[8:0]);
        end
      end
      prevWrEn = wrEn;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      check(1'b0, "WDOG", "timeout", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    waitCycles(5);
    // R8: reset state
    check(wrEn == 1'b0, "R8", "wrEn in reset", wrEn, 0);
    check(wrAddr == 7'd0, "R8", "wrAddr in reset", wrAddr, 0);
    check(wrData == 9'd0, "R8", "wrData in reset", wrData, 0);
    rstN = 1'b1;
    waitCycles(5);
    // R8/R6: latch straight after reset has no bits behind it
    pulseLatch();
    drain("R8");

    // R1 R2 R4: plain words with asymmetric patterns
    sendWord(32'h0000_A5C3, 16, 1'b1);
    sendWord(32'h0000_FE00, 16, 1'b1);
    sendWord(32'h0000_01FF, 16, 1'b1);
    drain("R2");

    // R5: outputs hold after the last write
    waitCycles(30);
    check(wrAddr == 7'h00 && wrData == 9'h1FF, "R5", "held value",
          {wrAddr, wrData}, 16'h01FF);

    // R3: longer frames keep only the last sixteen bits
    sendWord(32'h0005_3C96, 20, 1'b1);
    sendWord(32'hFFFF_1234, 32, 1'b1);
    drain("R3");

    // R6: short frames are rejected
    sendWord(32'h0000_2ABC, 15, 1'b0);
    sendWord(32'h0000_0001, 1, 1'b0);
    drain("R6");
    check(wrAddr == 7'h09 && wrData == 9'h034, "R6", "port unchanged after reject",
          {wrAddr, wrData}, 16'h1234);

    // R9: a rejected latch clears the count
    sendWord(32'h0000_03FF, 10, 1'b0);
    sendWord(32'h0000_0155, 10, 1'b0);
    sendWord(32'h0000_6E1D, 16, 1'b1);
    drain("R9");

    // R7: deselected traffic is ignored and not counted
    threeWireSel = 1'b0;
    sendWord(32'h0000_BEEF, 16, 1'b0);
    waitCycles(4);
    threeWireSel = 1'b1;
    waitCycles(4);
    pulseLatch();
    drain("R7");
    check(wrAddr == 7'h37 && wrData == 9'h01D, "R7", "port unchanged while idle",
          {wrAddr, wrData}, 16'h6E1D);
    sendWord(32'h0000_4321, 16, 1'b1);
    drain("R7");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule